// File: doc/BRIEF.md
# NAND Page Address Cycle Sequencer

This block turns a byte location inside a NAND flash array into the command and address bytes sent over an 8-bit flash bus. A request names a block (12 bits), a page within that block (5 bits), a column inside the 528-byte page (10 bits) and an operation. The block checks the request and packs the location into bytes. It then sends them one at a time on a byte stream. Each byte carries a tag that says whether the flash must latch it as a command or as an address.

The page register has three regions: a first half (columns 0..255), a second half (256..511) and a 16-byte spare area (512..527). Column bit 8 is never sent in an address byte. The opening pointer command carries it instead. The row address is block*32+page and fills three address bytes. The fourth address cycle carries only the top row bit. Both the request side and the byte side use a ready/valid handshake. A request for a location outside the array is dropped with a one-cycle error pulse, and no bytes are sent for it.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset, out_valid is 0, req_ready is 1 and req_err is 0.
- R2: The first byte of every sequence is a command (out_is_cmd=1). It is 8'h00 for columns 0..255, 8'h01 for columns 256..511 and 8'h50 for columns 512..527.
- R3: The first address byte (out_is_cmd=0) carries column bits 7:0 for columns below 512. For spare columns it carries column-512 in bits 3:0, with bits 7:4 zero.
- R4: With row = block*32+page, the second address byte carries row bits 7:0 and the third carries row bits 15:8.
- R5: The fourth address byte carries row bit 16 (the block MSB) in bit 0, with bits 7:1 zero.
- R6: A read request (req_op=0) yields exactly five bytes: one command, then four address bytes. After the last one is accepted, out_valid is 0 and req_ready is 1 on the next cycle.
- R7: A program request (req_op=1) yields the pointer command, then the command 8'h80, then the same four address bytes: six bytes in total.
- R8: While out_valid=1 and out_ready=0, out_byte and out_is_cmd hold their values.
- R9: A request with a column above 527, a page at or above 32 or a block at or above 4096 is accepted. One cycle later req_err pulses high for one cycle. No byte is presented, and req_ready stays 1.
- R10: req_ready is 0 while a sequence is being sent. A request held valid during that time is not taken and does not change the bytes being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_block | input | 12 | Block index |
| req_page | input | 5 | Page within block |
| req_col | input | 10 | Byte column within page |
| req_op | input | 1 | 0 = read pointer sequence, 1 = program sequence |
| req_err | output | 1 | One-cycle pulse: the last request was out of range |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_byte | output | 8 | Command or address byte |
| out_is_cmd | output | 1 | 1 = command-latch cycle, 0 = address-latch cycle |

## Verification
The bench drives columns on each side of the half and spare boundaries (255/256, 511/512, 527/528). A design that places the boundaries wrongly would send the wrong pointer command, or would leak column bit 8 into the first address byte. Block 4095 with page 31 sets the single bit in the fourth address cycle. A design that truncates the row, or lets junk into the upper bits, would show it there. Stalls on the byte side and a competing request held during a sequence expose designs that change a byte before it is taken or that accept work while busy. A rejected column is followed by a good request, to show that a rejected request leaves no bytes behind and does not corrupt the next one.

// File: rtl/nand_addr_pkg.sv
package nand_addr_pkg;
  typedef enum logic {
    OP_READ    = 1'b0,
    OP_PROGRAM = 1'b1
  } op_e;

  localparam logic [7:0] CMD_PTR_LO    = 8'h00;
  localparam logic [7:0] CMD_PTR_HI    = 8'h01;
  localparam logic [7:0] CMD_PTR_SPARE = 8'h50;
  localparam logic [7:0] CMD_PROG_SET  = 8'h80;
endpackage

// File: rtl/nand_addr_range_chk.sv
module nand_addr_range_chk #(
  parameter int BLK_W         = 12,
  parameter int PAGE_W        = 5,
  parameter int COL_W         = 10,
  parameter int NUM_BLOCKS    = 4096,
  parameter int PAGES_PER_BLK = 32,
  parameter int PAGE_BYTES    = 528
) (
  input  logic [BLK_W-1:0]  blk,
  input  logic [PAGE_W-1:0] page,
  input  logic [COL_W-1:0]  col,
  output logic              in_range
);
  logic blk_ok, page_ok, col_ok;

  always_comb begin
    blk_ok   = 32'(blk)  < NUM_BLOCKS;
    page_ok  = 32'(page) < PAGES_PER_BLK;
    col_ok   = 32'(col)  < PAGE_BYTES;
    in_range = blk_ok && page_ok && col_ok;
  end
endmodule

// File: rtl/nand_addr_packer.sv
module nand_addr_packer
  import nand_addr_pkg::*;
#(
  parameter int BLK_W      = 12,
  parameter int PAGE_W     = 5,
  parameter int COL_W      = 10,
  parameter int HALF_BYTES = 256,
  parameter int MAIN_BYTES = 512,
  localparam int ROW_W       = BLK_W + PAGE_W,
  localparam int ROW_BYTES   = (ROW_W + 7) / 8,
  localparam int ROW_PAD_W   = ROW_BYTES * 8,
  localparam int ADDR_CYCLES = 1 + ROW_BYTES,
  localparam int MAX_BYTES   = ADDR_CYCLES + 2,
  localparam int IDX_W       = $clog2(MAX_BYTES + 1)
) (
  input  logic [BLK_W-1:0]               blk,
  input  logic [PAGE_W-1:0]              page,
  input  logic [COL_W-1:0]               col,
  input  op_e                            op,
  output logic [MAX_BYTES-1:0][7:0]      seq_bytes,
  output logic [MAX_BYTES-1:0]           seq_cmd,
  output logic [IDX_W-1:0]               seq_len
);
  logic [ROW_PAD_W-1:0]            row_pad;
  logic [ADDR_CYCLES-1:0][7:0]     addr_b;
  logic [COL_W-1:0]                spare_off;
  logic [7:0]                      ptr_cmd;

  // Row = block * pages_per_block + page: concatenation, since pages is a power of two.
  assign row_pad   = ROW_PAD_W'({blk, page});
  assign spare_off = col - COL_W'(MAIN_BYTES);

  always_comb begin
    if (32'(col) >= MAIN_BYTES) begin
      ptr_cmd   = CMD_PTR_SPARE;
      addr_b[0] = 8'(spare_off);
    end else if (32'(col) >= HALF_BYTES) begin
      ptr_cmd   = CMD_PTR_HI;
      addr_b[0] = col[7:0];
    end else begin
      ptr_cmd   = CMD_PTR_LO;
      addr_b[0] = col[7:0];
    end
  end

  genvar g;
  generate
    for (g = 0; g < ROW_BYTES; g++) begin : g_row
      assign addr_b[g+1] = row_pad[g*8 +: 8];
    end
  endgenerate

  always_comb begin
    int base;
    seq_bytes    = '0;
    seq_cmd      = '0;
    seq_bytes[0] = ptr_cmd;
    seq_cmd[0]   = 1'b1;
    base         = 1;
    if (op == OP_PROGRAM) begin
      seq_bytes[1] = CMD_PROG_SET;
      seq_cmd[1]   = 1'b1;
      base         = 2;
    end
    for (int a = 0; a < ADDR_CYCLES; a++) begin
      seq_bytes[base + a] = addr_b[a];
    end
    seq_len = IDX_W'(base + ADDR_CYCLES);
  end
endmodule

// File: rtl/nand_addr_emitter.sv
module nand_addr_emitter #(
  parameter int MAX_BYTES = 6,
  localparam int IDX_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [MAX_BYTES-1:0][7:0] ld_bytes,
  input  logic [MAX_BYTES-1:0]      ld_cmd,
  input  logic [IDX_W-1:0]          ld_len,
  input  logic                      out_ready,
  output logic                      out_valid,
  output logic [7:0]                out_byte,
  output logic                      out_is_cmd
);
  logic [MAX_BYTES-1:0][7:0] seq_b;
  logic [MAX_BYTES-1:0]      seq_c;
  logic [IDX_W-1:0]          len_q;
  logic [IDX_W-1:0]          idx_q;
  logic [IDX_W-1:0]          idx_nxt;
  logic                      last_beat;

  assign idx_nxt   = idx_q + 1'b1;
  assign last_beat = (idx_q == len_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_byte   <= 8'h00;
      out_is_cmd <= 1'b0;
      idx_q      <= '0;
      len_q      <= '0;
    end else if (load) begin
      seq_b      <= ld_bytes;
      seq_c      <= ld_cmd;
      len_q      <= ld_len;
      idx_q      <= '0;
      out_valid  <= 1'b1;
      out_byte   <= ld_bytes[0];
      out_is_cmd <= ld_cmd[0];
    end else if (out_valid && out_ready) begin
      if (last_beat) begin
        out_valid <= 1'b0;
      end else begin
        idx_q      <= idx_nxt;
        out_byte   <= seq_b[idx_nxt];
        out_is_cmd <= seq_c[idx_nxt];
      end
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_is_cmd))); // R8

  AST_OPEN_WITH_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_is_cmd); // R2

  AST_NO_CMD_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_is_cmd) |=> (!out_valid || !out_is_cmd)); // R6

  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && last_beat) |=> !out_valid); // R6
endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
  import nand_addr_pkg::*;
#(
  parameter int BLK_W         = 12,
  parameter int PAGE_W        = 5,
  parameter int COL_W         = 10,
  parameter int NUM_BLOCKS    = 4096,
  parameter int PAGES_PER_BLK = 32,
  parameter int HALF_BYTES    = 256,
  parameter int MAIN_BYTES    = 512,
  parameter int PAGE_BYTES    = 528,
  localparam int ROW_W        = BLK_W + PAGE_W,
  localparam int ROW_BYTES    = (ROW_W + 7) / 8,
  localparam int ADDR_CYCLES  = 1 + ROW_BYTES,
  localparam int MAX_BYTES    = ADDR_CYCLES + 2,
  localparam int IDX_W        = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BLK_W-1:0]  req_block,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_op,
  output logic              req_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic              out_is_cmd
);
  logic                      in_range;
  logic                      accept;
  logic                      load;
  logic [MAX_BYTES-1:0][7:0] pk_bytes;
  logic [MAX_BYTES-1:0]      pk_cmd;
  logic [IDX_W-1:0]          pk_len;

  assign req_ready = !out_valid;
  assign accept    = req_valid && req_ready;
  assign load      = accept && in_range;

  nand_addr_range_chk #(
    .BLK_W(BLK_W), .PAGE_W(PAGE_W), .COL_W(COL_W),
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLK(PAGES_PER_BLK), .PAGE_BYTES(PAGE_BYTES)
  ) u_chk (
    .blk(req_block), .page(req_page), .col(req_col), .in_range(in_range)
  );

  nand_addr_packer #(
    .BLK_W(BLK_W), .PAGE_W(PAGE_W), .COL_W(COL_W),
    .HALF_BYTES(HALF_BYTES), .MAIN_BYTES(MAIN_BYTES)
  ) u_pack (
    .blk(req_block), .page(req_page), .col(req_col), .op(op_e'(req_op)),
    .seq_bytes(pk_bytes), .seq_cmd(pk_cmd), .seq_len(pk_len)
  );

  nand_addr_emitter #(.MAX_BYTES(MAX_BYTES)) u_emit (
    .clk(clk), .rst(rst), .load(load),
    .ld_bytes(pk_bytes), .ld_cmd(pk_cmd), .ld_len(pk_len),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_byte(out_byte), .out_is_cmd(out_is_cmd)
  );

  always_ff @(posedge clk) begin
    if (rst) req_err <= 1'b0;
    else     req_err <= accept && !in_range;
  end

  AST_ERR_NO_BYTES: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (!out_valid && req_ready)); // R9

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_err |=> !req_err); // R9
endmodule

// File: tb/nand_addr_seq_test.sv
module nand_addr_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_block = '0;
  logic [4:0]  req_page = '0;
  logic [9:0]  req_col = '0;
  logic        req_op = 1'b0;
  logic        req_err;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_byte;
  logic        out_is_cmd;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  nand_addr_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_block(req_block), .req_page(req_page), .req_col(req_col), .req_op(req_op),
    .req_err(req_err), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_is_cmd(out_is_cmd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected stream, computed from the requirements.
  task automatic expect_seq(input int blk, input int page, input int col, input bit op,
                            output int n, output int b[6], output bit c[6]);
    int row, ptr, a0, base;
    row  = blk * 32 + page;
    ptr  = (col < 256) ? 'h00 : (col < 512) ? 'h01 : 'h50;
    a0   = (col < 512) ? (col % 256) : (col - 512);
    b[0] = ptr; c[0] = 1'b1;
    base = 1;
    if (op) begin b[1] = 'h80; c[1] = 1'b1; base = 2; end
    b[base]   = a0;                  c[base]   = 1'b0;
    b[base+1] = row & 'hFF;          c[base+1] = 1'b0;
    b[base+2] = (row >> 8) & 'hFF;   c[base+2] = 1'b0;
    b[base+3] = (row >> 16) & 1;     c[base+3] = 1'b0;
    n = base + 4;
  endtask

  task automatic send(input int blk, input int page, input int col, input bit op);
    @(negedge clk);
    req_block = 12'(blk); req_page = 5'(page); req_col = 10'(col); req_op = op;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_seq(input string tag, input int blk, input int page, input int col, input bit op);
    int n; int b[6]; bit c[6];
    expect_seq(blk, page, col, op, n, b, c);
    send(blk, page, col, op);
    for (int i = 0; i < n; i++) begin
      chk($sformatf("%s valid[%0d]", tag, i), out_valid, 1);
      chk($sformatf("%s byte[%0d]", tag, i), out_byte, b[i]);
      chk($sformatf("%s tag[%0d]", tag, i), out_is_cmd, c[i]);
      chk($sformatf("%s busy[%0d] R10", tag, i), req_ready, 0);
      @(negedge clk);
    end
    chk({tag, " end valid R6"}, out_valid, 0);
    chk({tag, " end ready R6"}, req_ready, 1);
  endtask

  task automatic t_reset;
    chk("R1 out_valid", out_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 req_err", req_err, 0);
  endtask

  task automatic t_main_low;
    run_seq("R2 R3 R4 R6 zero", 0, 0, 0, 1'b0);
    run_seq("R2 R3 R4 R5 max-row col255", 4095, 31, 255, 1'b0);
    run_seq("R4 R5 mid", 2048, 1, 17, 1'b0);
  endtask

  task automatic t_main_high;
    run_seq("R2 R3 col256", 'h5A3, 17, 256, 1'b0);
    run_seq("R2 R3 col511", 'h5A3, 17, 511, 1'b0);
  endtask

  task automatic t_spare;
    run_seq("R2 R3 spare512", 77, 3, 512, 1'b0);
    run_seq("R2 R3 spare527", 4094, 30, 527, 1'b0);
  endtask

  task automatic t_program;
    run_seq("R7 prog lo", 1234, 9, 100, 1'b1);
    run_seq("R7 prog spare", 4095, 31, 520, 1'b1);
  endtask

  task automatic t_reject;
    send(1, 2, 528, 1'b0);
    chk("R9 err pulse", req_err, 1);
    chk("R9 no bytes", out_valid, 0);
    chk("R9 ready", req_ready, 1);
    @(negedge clk);
    chk("R9 err one cycle", req_err, 0);
    chk("R9 still no bytes", out_valid, 0);
    send(4095, 31, 1023, 1'b1);
    chk("R9 err pulse 1023", req_err, 1);
    chk("R9 no bytes 1023", out_valid, 0);
    run_seq("R9 follow-up", 3, 4, 5, 1'b0);
  endtask

  task automatic t_backpressure;
    int n; int b[6]; bit c[6];
    expect_seq(300, 12, 400, 1'b1, n, b, c);
    out_ready = 1'b0;
    send(300, 12, 400, 1'b1);
    // competing request held while busy
    req_block = 12'd1; req_page = 5'd0; req_col = 10'd0; req_op = 1'b0; req_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chk("R8 stall byte0", out_byte, b[0]);
      chk("R8 stall tag0", out_is_cmd, c[0]);
      chk("R10 ready low", req_ready, 0);
      @(negedge clk);
    end
    for (int i = 0; i < n; i++) begin
      chk($sformatf("R8 byte[%0d]", i), out_byte, b[i]);
      out_ready = 1'b0;
      @(negedge clk);
      chk($sformatf("R8 held byte[%0d]", i), out_byte, b[i]);
      chk($sformatf("R8 held tag[%0d]", i), out_is_cmd, c[i]);
      if (i == n - 1) req_valid = 1'b0;
      out_ready = 1'b1;
      @(negedge clk);
    end
    chk("R10 end valid", out_valid, 0);
    @(negedge clk);
    chk("R10 competing request not taken", out_valid, 0);
    out_ready = 1'b1;
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
        finish_up();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_main_low();
    t_main_high();
    t_spare();
    t_program();
    t_reject();
    t_backpressure();
    finish_up();
  end
endmodule